// File: doc/BRIEF.md
# Edge-Triggered Counter Capture Channel

This block takes a snapshot of a 16-bit free-running counter when a chosen input signal makes a chosen transition. One of three candidate inputs is picked by a 2-bit source field. The value 00 of that field puts the channel in output mode, and in output mode nothing is captured. The source field can only be loaded while the channel is switched off. Each candidate input passes through a two-stage synchroniser. A polarity bit then selects whether rising or falling transitions count as events.

An event divider sits ahead of the capture register. Depending on a 2-bit field, it passes every event, every second event, every fourth event or every eighth event. A capture stores the counter value in the capture register and sets a status flag. The interrupt request is the flag gated by an interrupt-enable input. Software clears the flag with a one-cycle clear strobe. If a capture occurs in the same cycle as the strobe, the capture wins.

Top module: `capture_channel`

## Requirements
- R1: Source field 00 is output mode and no capture happens. The values 01, 10 and 11 take events from `src_i[0]`, `src_i[1]` and `src_i[2]` respectively, and only from that input.
- R2: A source write (`sel_wr_i` high) takes effect on the next clock edge only if `en_i` is 0. A write while `en_i` is 1 leaves `sel_o` unchanged.
- R3: Divider field 00 (the default after reset) captures on every qualifying edge.
- R4: Divider fields 01, 10 and 11 capture on the 2nd, 4th and 8th qualifying edge respectively. No capture happens on the edges in between.
- R5: The capture register loads the value of `cnt_i` present in the cycle the capture fires. A transition applied on `src_i` is captured on the third rising clock edge after it, because of the two synchroniser stages and the edge register.
- R6: With `pol_i` = 0 only rising transitions count as events. With `pol_i` = 1 only falling transitions count.
- R7: A capture sets `flag_o`. `irq_o` is high exactly when `flag_o` and `ie_i` are both 1.
- R8: A one-cycle `flag_clr_i` clears `flag_o` at the next edge. A capture in the same cycle as the clear keeps the flag set.
- R9: The divider event count returns to zero whenever `en_i` is 0 or the divider field changes value.
- R10: After a synchronous reset, `cap_o` is 0, `flag_o` is 0, `irq_o` is 0 and `sel_o` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | 16 | Free-running counter value |
| src_i | input | 3 | Candidate asynchronous inputs |
| pol_i | input | 1 | Edge polarity: 0 rising, 1 falling |
| en_i | input | 1 | Channel enable |
| sel_wr_i | input | 1 | Source field write strobe |
| sel_wdata_i | input | 2 | Source field write value |
| psc_i | input | 2 | Event divider field |
| ie_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Flag clear strobe |
| cap_o | output | 16 | Capture register |
| flag_o | output | 1 | Capture flag |
| irq_o | output | 1 | Interrupt request |
| sel_o | output | 2 | Current source field |

## Verification
The embedded properties check several rules on every cycle:
- the source field stays frozen while the channel is enabled;
- nothing is captured in output mode;
- the divider count stays within its limit and returns to zero when the channel is off;
- divide-by-1 fires on every event;
- a capture loads the counter and sets the flag;
- a clear with no capture in the same cycle empties the flag.

Only the bench scenarios can show the behaviour that depends on sequences of edges:
- which input each source value maps to;
- polarity selection;
- the exact Nth-edge timing of each divider;
- the divider restart after a disable or a field change;
- the capture-over-clear race observed at the ports.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int CNT_W   = 16;
    localparam int NSRC    = 3;
    localparam int DIV_W   = 3;

    typedef enum logic [1:0] {
        SEL_OUT  = 2'b00,
        SEL_IN_A = 2'b01,
        SEL_IN_B = 2'b10,
        SEL_IN_C = 2'b11
    } sel_e;

    typedef enum logic [1:0] {
        DIV1 = 2'b00,
        DIV2 = 2'b01,
        DIV4 = 2'b10,
        DIV8 = 2'b11
    } div_e;

    typedef struct packed {
        logic [CNT_W-1:0] value;
        logic             flag;
    } cap_state_t;

    function automatic logic [DIV_W-1:0] div_last(div_e d);
        logic [DIV_W:0] n;
        n = (DIV_W+1)'(1) << d;
        return DIV_W'(n - 1'b1);
    endfunction

    function automatic logic is_input(sel_e s);
        return s != SEL_OUT;
    endfunction

endpackage

// File: rtl/cap_edge.sv
module cap_edge
    import cap_pkg::*;
#(
    parameter int N_SRC = NSRC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_i,
    input  logic             pol_i,
    input  sel_e             sel_i,
    output logic             evt_o
);

    logic [N_SRC-1:0] stg1_q;
    logic [N_SRC-1:0] stg2_q;
    logic [N_SRC-1:0] last_q;
    logic [N_SRC-1:0] edge_v;

    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_src
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg1_q[g] <= 1'b0;
                    stg2_q[g] <= 1'b0;
                    last_q[g] <= 1'b0;
                end else begin
                    stg1_q[g] <= src_i[g];
                    stg2_q[g] <= stg1_q[g];
                    last_q[g] <= stg2_q[g];
                end
            end

            always_comb begin
                if (pol_i) edge_v[g] = last_q[g] & ~stg2_q[g];
                else       edge_v[g] = stg2_q[g] & ~last_q[g];
            end
        end
    endgenerate

    always_comb begin
        evt_o = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (int'(sel_i) == i + 1) evt_o = edge_v[i];
        end
    end

    // R1
    out_mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_i == SEL_OUT) |-> !evt_o);

endmodule

// File: rtl/cap_prescale.sv
module cap_prescale
    import cap_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic clk,
    input  logic rst,
    input  logic act_i,
    input  logic evt_i,
    input  div_e div_i,
    output logic fire_o
);

    logic [W-1:0] cnt_q;
    div_e         div_q;
    logic         restart;
    logic         at_last;

    assign restart = !act_i || (div_i != div_q);
    assign at_last = (cnt_q == div_last(div_i));
    assign fire_o  = evt_i && !restart && at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            div_q <= DIV1;
        end else begin
            div_q <= div_i;
            if (restart)      cnt_q <= '0;
            else if (evt_i)   cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end

    // R4
    div_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= div_last(div_q));

    // R9
    div_restart_chk: assert property (@(posedge clk) disable iff (rst)
        !act_i |=> cnt_q == '0);

    // R3
    div_one_chk: assert property (@(posedge clk) disable iff (rst)
        (act_i && evt_i && div_i == DIV1 && div_q == DIV1) |-> fire_o);

endmodule

// File: rtl/cap_store.sv
module cap_store
    import cap_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fire_i,
    input  logic [W-1:0] cnt_i,
    input  logic         clr_i,
    output logic [W-1:0] cap_o,
    output logic         flag_o
);

    cap_state_t st_q;
    cap_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (clr_i)  st_d.flag = 1'b0;
        if (fire_i) begin
            st_d.value = cnt_i;
            st_d.flag  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cap_o  = st_q.value;
    assign flag_o = st_q.flag;

    // R5
    cap_load_chk: assert property (@(posedge clk) disable iff (rst)
        fire_i |=> cap_o == $past(cnt_i));

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        fire_i |=> flag_o);

    // R8
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !fire_i) |=> !flag_o);

endmodule

// File: rtl/capture_channel.sv
module capture_channel
    import cap_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int NS = NSRC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt_i,
    input  logic [NS-1:0] src_i,
    input  logic          pol_i,
    input  logic          en_i,
    input  logic          sel_wr_i,
    input  logic [1:0]    sel_wdata_i,
    input  logic [1:0]    psc_i,
    input  logic          ie_i,
    input  logic          flag_clr_i,
    output logic [CW-1:0] cap_o,
    output logic          flag_o,
    output logic          irq_o,
    output logic [1:0]    sel_o
);

    sel_e sel_q;
    logic active;
    logic evt;
    logic fire;

    always_ff @(posedge clk) begin
        if (rst)                   sel_q <= SEL_OUT;
        else if (sel_wr_i && !en_i) sel_q <= sel_e'(sel_wdata_i);
    end

    assign active = en_i && is_input(sel_q);
    assign sel_o  = sel_q;

    cap_edge #(.N_SRC(NS)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .src_i (src_i),
        .pol_i (pol_i),
        .sel_i (sel_q),
        .evt_o (evt)
    );

    cap_prescale #(.W(DIV_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .act_i  (active),
        .evt_i  (evt),
        .div_i  (div_e'(psc_i)),
        .fire_o (fire)
    );

    cap_store #(.W(CW)) u_store (
        .clk    (clk),
        .rst    (rst),
        .fire_i (fire),
        .cnt_i  (cnt_i),
        .clr_i  (flag_clr_i),
        .cap_o  (cap_o),
        .flag_o (flag_o)
    );

    assign irq_o = flag_o & ie_i;

    // R2
    sel_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        en_i |=> sel_q == $past(sel_q));

    // R1
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_q == SEL_OUT) |=> $stable(cap_o));

endmodule

// File: tb/capture_channel_bench.sv
module capture_channel_bench;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cnt_i = '0;
    logic [2:0]  src_i = '0;
    logic        pol_i = 1'b0;
    logic        en_i = 1'b0;
    logic        sel_wr_i = 1'b0;
    logic [1:0]  sel_wdata_i = '0;
    logic [1:0]  psc_i = '0;
    logic        ie_i = 1'b0;
    logic        flag_clr_i = 1'b0;
    logic [15:0] cap_o;
    logic        flag_o, irq_o;
    logic [1:0]  sel_o;

    always #(PERIOD/2) clk = ~clk;

    capture_channel u_capture_channel (
        .clk(clk), .rst(rst), .cnt_i(cnt_i), .src_i(src_i), .pol_i(pol_i),
        .en_i(en_i), .sel_wr_i(sel_wr_i), .sel_wdata_i(sel_wdata_i),
        .psc_i(psc_i), .ie_i(ie_i), .flag_clr_i(flag_clr_i),
        .cap_o(cap_o), .flag_o(flag_o), .irq_o(irq_o), .sel_o(sel_o)
    );

    typedef struct {
        string       tag;
        logic [15:0] cap;
        logic        flag;
        logic        irq;
        logic [1:0]  sel;
    } item_t;

    item_t q[$];
    int    applied = 0;
    int    bad = 0;
    bit    done = 0;

    logic [15:0] e_cap = '0;
    logic        e_flag = 1'b0;
    logic [1:0]  e_sel = '0;

    initial begin : monitor
        item_t it;
        forever begin
            wait (q.size() != 0);
            #1;
            it = q.pop_front();
            applied++;
            if (cap_o !== it.cap || flag_o !== it.flag || irq_o !== it.irq || sel_o !== it.sel) begin
                bad++;
                $display("FAIL %s: cap=%h flag=%b irq=%b sel=%b expected cap=%h flag=%b irq=%b sel=%b",
                         it.tag, cap_o, flag_o, irq_o, sel_o, it.cap, it.flag, it.irq, it.sel);
            end
        end
    end

    task automatic expect_now(input string tag);
        item_t it;
        it.tag  = tag;
        it.cap  = e_cap;
        it.flag = e_flag;
        it.irq  = e_flag & ie_i;
        it.sel  = e_sel;
        q.push_back(it);
        wait (q.size() == 0);
        #2;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_sel(input logic [1:0] v);
        en_i = 1'b0;
        step(1);
        sel_wr_i = 1'b1;
        sel_wdata_i = v;
        step(1);
        sel_wr_i = 1'b0;
        e_sel = v;
        en_i = 1'b1;
        step(1);
    endtask

    task automatic toggle(input int i, input logic [15:0] v);
        cnt_i = v;
        src_i[i] = ~src_i[i];
        step(5);
    endtask

    task automatic rise(input int i, input logic [15:0] v);
        if (src_i[i]) toggle(i, 16'hDEAD);
        toggle(i, v);
    endtask

    task automatic clear_flag();
        flag_clr_i = 1'b1;
        step(1);
        flag_clr_i = 1'b0;
        step(1);
        e_flag = 1'b0;
    endtask

    initial begin : watchdog
        #(PERIOD * 200000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

    initial begin : driver
        step(3);
        rst = 1'b0;
        step(1);
        expect_now("R10 reset state");

        // R3 R5: every rising edge captures the counter value
        write_sel(2'b01);
        rise(0, 16'h1111);
        e_cap = 16'h1111; e_flag = 1'b1;
        expect_now("R3 R5 capture on rising edge");

        // R6: falling edge ignored with pol 0
        toggle(0, 16'h2222);
        expect_now("R6 falling edge ignored");

        // R8: clear
        clear_flag();
        expect_now("R8 clear flag");

        // R7: interrupt enabled
        ie_i = 1'b1;
        rise(0, 16'h3333);
        e_cap = 16'h3333; e_flag = 1'b1;
        expect_now("R7 irq raised with enable");

        ie_i = 1'b0;
        step(1);
        expect_now("R7 irq masked");
        ie_i = 1'b1;
        clear_flag();
        expect_now("R8 clear before race");

        // R8: capture in same cycle as clear wins
        toggle(0, 16'hDEAD);
        cnt_i = 16'h4444;
        src_i[0] = 1'b1;
        step(2);
        flag_clr_i = 1'b1;
        step(1);
        flag_clr_i = 1'b0;
        step(3);
        e_cap = 16'h4444; e_flag = 1'b1;
        expect_now("R8 capture wins over clear");

        // R2: write while enabled ignored
        sel_wr_i = 1'b1; sel_wdata_i = 2'b10;
        step(1);
        sel_wr_i = 1'b0;
        step(1);
        expect_now("R2 write ignored while enabled");
        write_sel(2'b10);
        expect_now("R2 write taken while disabled");

        // R1: source 10 picks src_i[1] only
        rise(0, 16'h5555);
        expect_now("R1 unselected input ignored");
        rise(1, 16'h6666);
        e_cap = 16'h6666;
        expect_now("R1 selected input captured");

        // R6: falling polarity
        pol_i = 1'b1;
        step(1);
        toggle(1, 16'h7777);
        e_cap = 16'h7777;
        expect_now("R6 falling edge captured with pol 1");
        pol_i = 1'b0;
        step(1);

        // R1: output mode
        clear_flag();
        write_sel(2'b00);
        rise(0, 16'h0BAD);
        rise(1, 16'h0BAD);
        rise(2, 16'h0BAD);
        expect_now("R1 output mode no capture");

        // R4: divide by 4 on src_i[2]
        write_sel(2'b11);
        psc_i = 2'b10;
        step(1);
        for (int k = 1; k <= 3; k++) rise(2, 16'h0A00 + 16'(k));
        expect_now("R4 div4 no capture before 4th edge");
        rise(2, 16'h0A04);
        e_cap = 16'h0A04; e_flag = 1'b1;
        expect_now("R4 div4 capture on 4th edge");

        // R4: divide by 8
        psc_i = 2'b11;
        clear_flag();
        for (int k = 1; k <= 7; k++) rise(2, 16'h0B00 + 16'(k));
        expect_now("R4 div8 no capture before 8th edge");
        rise(2, 16'h0B08);
        e_cap = 16'h0B08; e_flag = 1'b1;
        expect_now("R4 div8 capture on 8th edge");

        // R4: divide by 2
        psc_i = 2'b01;
        clear_flag();
        rise(2, 16'h0C01);
        expect_now("R4 div2 no capture on 1st edge");
        rise(2, 16'h0C02);
        e_cap = 16'h0C02; e_flag = 1'b1;
        expect_now("R4 div2 capture on 2nd edge");

        // R9: disable restarts the count
        clear_flag();
        rise(2, 16'h0D01);
        en_i = 1'b0;
        step(1);
        en_i = 1'b1;
        step(1);
        rise(2, 16'h0D02);
        expect_now("R9 count restarted by disable");
        rise(2, 16'h0D03);
        e_cap = 16'h0D03; e_flag = 1'b1;
        expect_now("R9 capture after restart");

        // R9: divider change restarts the count
        clear_flag();
        rise(2, 16'h0E01);
        psc_i = 2'b10;
        step(1);
        for (int k = 2; k <= 4; k++) rise(2, 16'h0E00 + 16'(k));
        expect_now("R9 count restarted by divider change");
        rise(2, 16'h0E05);
        e_cap = 16'h0E05; e_flag = 1'b1;
        expect_now("R9 capture after divider change");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

endmodule